// File: doc/BRIEF.md
# Paired-Page Address Translation Buffer

This block turns a 32-bit virtual address into a physical address by searching a small, fully associative set of translation entries, all compared in parallel. Each entry covers two neighbouring 4 KB pages that share one tag, and each of the two halves has its own frame number, valid flag and dirty flag. An entry carries an 8-bit address-space identifier. It also carries a global flag, and when that flag is set the identifier comparison is skipped.

The lookup path is purely combinational. The caller presents the virtual address, the current address-space identifier and a write flag, and reads the hit flag, the physical address and a fault class in the same cycle. There are three fault classes. A miss means no entry matched. An invalid fault means an entry matched but the selected half is not valid. A modify fault means a write hit a valid half whose dirty flag is clear. Entries are loaded one at a time through a clocked write port. A write can either install an entry or remove it.

Top module: `tlb_xlate`

## Requirements
- R1: An entry is a candidate only if it is present and its stored tag equals virtual address bits 31:13.
- R2: A candidate matches when its global flag is set or its stored identifier equals `asid_i`. A non-global entry whose identifier differs is treated as absent.
- R3: Virtual address bit 12 selects the half. A value of 0 selects the even half, with valid bit 0, dirty bit 0 and `wr_pfn_even_i`. A value of 1 selects the odd half, with valid bit 1, dirty bit 1 and `wr_pfn_odd_i`.
- R4: On a hit, `paddr_o` equals the selected 20-bit frame number in bits 31:12 and virtual address bits 11:0 in bits 11:0, and `hit_o` is 1. When there is no hit, `paddr_o` is 0 and `hit_o` is 0.
- R5: When no entry matches, `fault_o` is 2'b01 (miss).
- R6: When a matching entry's selected valid bit is 0, `fault_o` is 2'b10 (invalid). This holds for reads and writes alike.
- R7: A write (`we_i`=1) to a valid half whose dirty bit is 0 gives `fault_o` = 2'b11 (modify). A read to the same half hits, because reads ignore the dirty bit. A clean lookup gives `fault_o` = 2'b00.
- R8: When several entries match, the entry with the lowest index supplies the result.
- R9: Asynchronous reset makes every entry absent, so every lookup misses afterwards, including virtual address 0 with identifier 0.
- R10: When `wr_en_i` is 1 at a rising clock edge, entry `wr_idx_i` is loaded with the write-port fields and is present if `wr_live_i` is 1. When `wr_live_i` is 0, the entry is removed. The change is visible from the cycle after that edge.
- R11: A lookup result reflects the lookup inputs presented in the same cycle, with no clock latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the write port |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Load one entry at this edge |
| wr_idx_i | input | 4 | Entry slot to load |
| wr_live_i | input | 1 | 1 installs the entry, 0 removes it |
| wr_vpn2_i | input | 19 | Page-pair tag (virtual address bits 31:13) |
| wr_asid_i | input | 8 | Address-space identifier of the entry |
| wr_global_i | input | 1 | Skip the identifier comparison |
| wr_valid_i | input | 2 | Valid flags, bit 0 even half, bit 1 odd half |
| wr_dirty_i | input | 2 | Dirty flags, bit 0 even half, bit 1 odd half |
| wr_pfn_even_i | input | 20 | Frame number of the even half |
| wr_pfn_odd_i | input | 20 | Frame number of the odd half |
| va_i | input | 32 | Virtual address to translate |
| asid_i | input | 8 | Current address-space identifier |
| we_i | input | 1 | Lookup is for a write |
| hit_o | output | 1 | Translation succeeded |
| fault_o | output | 2 | 00 none, 01 miss, 10 invalid, 11 modify |
| paddr_o | output | 32 | Translated physical address, 0 when there is no hit |

## Verification
Lookup results are due in the same cycle as their inputs. The driver applies each lookup 1 ns after a rising edge and queues the expected result. The monitor pops and compares that result at the following falling edge, before the next lookup replaces the inputs. A table write is due one edge after the write port is strobed. For that reason every lookup that depends on a write is issued in a later cycle than the edge that completed the write.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int VA_W   = 32;
  parameter int PAGE_W = 12;
  parameter int ASID_W = 8;
  parameter int PFN_W  = 20;

  localparam int VPN2_W = VA_W - PAGE_W - 1;
  localparam int PA_W   = PFN_W + PAGE_W;

  typedef struct packed {
    logic                  live;
    logic [VPN2_W-1:0]     vpn2;
    logic [ASID_W-1:0]     asid;
    logic                  glob;
    logic [1:0]            valid;
    logic [1:0]            dirty;
    logic [1:0][PFN_W-1:0] pfn;
  } tlb_entry_t;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'b00,
    FLT_MISS    = 2'b01,
    FLT_INVALID = 2'b10,
    FLT_MODIFY  = 2'b11
  } fault_e;
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int N     = 16,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  tlb_entry_t            wr_entry_i,
  input  logic [VPN2_W-1:0]     va_vpn2_i,
  input  logic [ASID_W-1:0]     asid_i,
  output tlb_entry_t [N-1:0]    ent_o,
  output logic [N-1:0]          match_o
);

  for (genvar g = 0; g < N; g++) begin : g_ent
    tlb_entry_t ent_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q <= '0;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
        ent_q <= wr_entry_i;
      end
    end

    assign ent_o[g]   = ent_q;
    // global entries skip the identifier compare
    assign match_o[g] = ent_q.live && (ent_q.vpn2 == va_vpn2_i) &&
                        (ent_q.glob || (ent_q.asid == asid_i));
  end

  assert_write_lands_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_entry_i.live && (int'(wr_idx_i) < N)) |=>
      ent_o[$past(wr_idx_i)].live);

  assert_remove_lands_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_entry_i.live && (int'(wr_idx_i) < N)) |=>
      !match_o[$past(wr_idx_i)]);

endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
  parameter int N     = 16,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     match_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     grant_o
);

  // scan downward so the lowest matching index is kept last
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
    grant_o = found_o ? (N'(1) << idx_o) : '0;
  end

  assert_grant_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o) && ((grant_o & ~match_i) == '0));

  assert_grant_lowest_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> ((match_i & (grant_o - N'(1))) == '0));

endmodule

// File: rtl/tlb_resolve.sv
module tlb_resolve
  import tlb_pkg::*;
(
  input  logic              found_i,
  input  tlb_entry_t        ent_i,
  input  logic              odd_i,
  input  logic              we_i,
  input  logic [PAGE_W-1:0] offset_i,
  output logic              hit_o,
  output fault_e            fault_o,
  output logic [PA_W-1:0]   paddr_o
);

  logic             half_valid;
  logic             half_dirty;
  logic [PFN_W-1:0] half_pfn;

  assign half_valid = ent_i.valid[odd_i];
  assign half_dirty = ent_i.dirty[odd_i];
  assign half_pfn   = ent_i.pfn[odd_i];

  always_comb begin
    if (!found_i)                  fault_o = FLT_MISS;
    else if (!half_valid)          fault_o = FLT_INVALID;
    else if (we_i && !half_dirty)  fault_o = FLT_MODIFY;
    else                           fault_o = FLT_NONE;
  end

  assign hit_o   = (fault_o == FLT_NONE);
  assign paddr_o = hit_o ? {half_pfn, offset_i} : '0;

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [IDX_W-1:0]         wr_idx_i,
  input  logic                     wr_live_i,
  input  logic [VA_W-PAGE_W-2:0]   wr_vpn2_i,
  input  logic [ASID_W-1:0]        wr_asid_i,
  input  logic                     wr_global_i,
  input  logic [1:0]               wr_valid_i,
  input  logic [1:0]               wr_dirty_i,
  input  logic [PFN_W-1:0]         wr_pfn_even_i,
  input  logic [PFN_W-1:0]         wr_pfn_odd_i,
  input  logic [VA_W-1:0]          va_i,
  input  logic [ASID_W-1:0]        asid_i,
  input  logic                     we_i,
  output logic                     hit_o,
  output logic [1:0]               fault_o,
  output logic [PFN_W+PAGE_W-1:0]  paddr_o
);

  tlb_entry_t               wr_entry;
  tlb_entry_t [ENTRIES-1:0] ents;
  tlb_entry_t               sel_ent;
  logic [ENTRIES-1:0]       match_vec;
  logic [ENTRIES-1:0]       grant;
  logic                     found;
  logic [IDX_W-1:0]         sel_idx;
  fault_e                   fault;

  always_comb begin
    wr_entry        = '0;
    wr_entry.live   = wr_live_i;
    wr_entry.vpn2   = wr_vpn2_i;
    wr_entry.asid   = wr_asid_i;
    wr_entry.glob   = wr_global_i;
    wr_entry.valid  = wr_valid_i;
    wr_entry.dirty  = wr_dirty_i;
    wr_entry.pfn[0] = wr_pfn_even_i;
    wr_entry.pfn[1] = wr_pfn_odd_i;
  end

  tlb_entry_store #(.N(ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_idx_i   (wr_idx_i),
    .wr_entry_i (wr_entry),
    .va_vpn2_i  (va_i[VA_W-1:PAGE_W+1]),
    .asid_i     (asid_i),
    .ent_o      (ents),
    .match_o    (match_vec)
  );

  tlb_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .match_i (match_vec),
    .found_o (found),
    .idx_o   (sel_idx),
    .grant_o (grant)
  );

  assign sel_ent = ents[sel_idx];

  tlb_resolve u_resolve (
    .found_i  (found),
    .ent_i    (sel_ent),
    .odd_i    (va_i[PAGE_W]),
    .we_i     (we_i),
    .offset_i (va_i[PAGE_W-1:0]),
    .hit_o    (hit_o),
    .fault_o  (fault),
    .paddr_o  (paddr_o)
  );

  assign fault_o = fault;

  assert_offset_pass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (paddr_o[PAGE_W-1:0] == va_i[PAGE_W-1:0]));

  assert_nohit_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (paddr_o == '0));

  assert_miss_nomatch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o == FLT_MISS) == (grant == '0));

  assert_modify_on_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o == FLT_MODIFY) |-> we_i);

endmodule

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;
  localparam real HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic        wr_live = 1'b0;
  logic [18:0] wr_vpn2 = '0;
  logic [7:0]  wr_asid = '0;
  logic        wr_glob = 1'b0;
  logic [1:0]  wr_valid = '0;
  logic [1:0]  wr_dirty = '0;
  logic [19:0] wr_pfn_e = '0;
  logic [19:0] wr_pfn_o = '0;
  logic [31:0] va = '0;
  logic [7:0]  asid = '0;
  logic        we = 1'b0;
  logic        hit;
  logic [1:0]  fault;
  logic [31:0] paddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic        hit;
    logic [1:0]  fault;
    logic [31:0] pa;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #(HALF) clk = ~clk;

  tlb_xlate uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_live_i(wr_live), .wr_vpn2_i(wr_vpn2), .wr_asid_i(wr_asid),
    .wr_global_i(wr_glob), .wr_valid_i(wr_valid), .wr_dirty_i(wr_dirty),
    .wr_pfn_even_i(wr_pfn_e), .wr_pfn_odd_i(wr_pfn_o), .va_i(va),
    .asid_i(asid), .we_i(we), .hit_o(hit), .fault_o(fault), .paddr_o(paddr)
  );

  // monitor: lookup is combinational, result due in the cycle it is driven
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (hit !== e.hit || fault !== e.fault || paddr !== e.pa) begin
        errors++;
        $display("FAIL %s: got hit=%b fault=%b pa=%h, expected hit=%b fault=%b pa=%h",
                 e.tag, hit, fault, paddr, e.hit, e.fault, e.pa);
      end
    end
  end

  task automatic load(input logic [3:0] idx, input logic live, input logic [31:0] base,
                      input logic [7:0] a, input logic g, input logic [1:0] v,
                      input logic [1:0] d, input logic [19:0] pe, input logic [19:0] po);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_idx = idx; wr_live = live; wr_vpn2 = base[31:13];
    wr_asid = a; wr_glob = g; wr_valid = v; wr_dirty = d;
    wr_pfn_e = pe; wr_pfn_o = po;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [31:0] a_va, input logic [7:0] a_id, input logic a_we,
                      input logic [1:0] e_fault, input logic [31:0] e_pa, input string tag);
    exp_t e;
    @(posedge clk); #1;
    va = a_va; asid = a_id; we = a_we;
    e.hit = (e_fault == 2'b00); e.fault = e_fault; e.pa = e_pa; e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin
    #(200000 * 2 * HALF);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    look(32'h0000_0000, 8'h00, 1'b0, 2'b01, 32'h0, "R9 reset all absent");
    look(32'h0040_0123, 8'h05, 1'b0, 2'b01, 32'h0, "R5 empty miss");

    load(4'd0, 1'b1, 32'h0040_0000, 8'h05, 1'b0, 2'b11, 2'b01, 20'h12345, 20'h0ABCD);
    look(32'h0040_0123, 8'h05, 1'b0, 2'b00, 32'h1234_5123, "R1 R3 R4 R10 even read");
    look(32'h0040_1FFF, 8'h05, 1'b0, 2'b00, 32'h0ABC_DFFF, "R3 odd read clean ok R7");
    look(32'h0040_0123, 8'h06, 1'b0, 2'b01, 32'h0, "R2 asid mismatch");
    look(32'h0040_0010, 8'h05, 1'b1, 2'b00, 32'h1234_5010, "R7 write dirty half");
    look(32'h0040_1010, 8'h05, 1'b1, 2'b11, 32'h0, "R7 write clean half");
    look(32'h0040_2000, 8'h05, 1'b0, 2'b01, 32'h0, "R1 tag mismatch");

    load(4'd3, 1'b1, 32'h8000_0000, 8'h09, 1'b1, 2'b01, 2'b11, 20'h00111, 20'h00222);
    look(32'h8000_0ABC, 8'h33, 1'b0, 2'b00, 32'h0011_1ABC, "R2 global bypass");
    look(32'h8000_1ABC, 8'h33, 1'b0, 2'b10, 32'h0, "R6 invalid read");
    look(32'h8000_1000, 8'h09, 1'b1, 2'b10, 32'h0, "R6 invalid write");

    load(4'd7, 1'b1, 32'h1000_0000, 8'h01, 1'b0, 2'b11, 2'b11, 20'h77777, 20'h77770);
    look(32'h1000_0004, 8'h01, 1'b0, 2'b00, 32'h7777_7004, "R11 single match");
    load(4'd2, 1'b1, 32'h1000_0000, 8'h01, 1'b0, 2'b11, 2'b11, 20'h22222, 20'h22220);
    look(32'h1000_0004, 8'h01, 1'b0, 2'b00, 32'h2222_2004, "R8 lowest index wins");
    load(4'd2, 1'b0, 32'h1000_0000, 8'h01, 1'b0, 2'b11, 2'b11, 20'h22222, 20'h22220);
    look(32'h1000_0004, 8'h01, 1'b0, 2'b00, 32'h7777_7004, "R10 removal");

    load(4'd15, 1'b1, 32'hFFFF_E000, 8'hFF, 1'b0, 2'b10, 2'b10, 20'h00000, 20'hFFFFF);
    look(32'hFFFF_F001, 8'hFF, 1'b1, 2'b00, 32'hFFFF_F001, "R10 top slot write");
    look(32'hFFFF_E001, 8'hFF, 1'b0, 2'b10, 32'h0, "R6 top slot even invalid");

    load(4'd0, 1'b1, 32'h0040_0000, 8'h44, 1'b0, 2'b11, 2'b11, 20'h55555, 20'h66666);
    look(32'h0040_0123, 8'h05, 1'b0, 2'b01, 32'h0, "R10 overwrite old asid");
    look(32'h0040_1123, 8'h44, 1'b1, 2'b00, 32'h6666_6123, "R10 overwrite new asid");

    @(posedge clk); #1;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    look(32'h8000_0ABC, 8'h33, 1'b0, 2'b01, 32'h0, "R9 reset clears global");
    look(32'h0040_1123, 8'h44, 1'b0, 2'b01, 32'h0, "R9 reset clears entry");

    @(posedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule